// File: doc/BRIEF.md
# Modem Transmit Task Buffer Controller

This block is the host-facing transmit side of a packet data modem. The host fills a small data buffer one byte at a time and then writes a task code. The code sets how many buffered bytes make up the block. Once the internal transmit stage is free, the block copies the buffer into that stage. It then shifts the bytes out as 2-bit symbols, one symbol per strobe of a programmable divider. When no data is queued, a selectable filler symbol goes out instead.

Two status flags form a two-stage handshake. The buffer-free flag tells the host that it may load the next block while the current one is still being sent. The input-empty flag tells the host that the stage has run dry, and it rises after the closing block of a frame. Every symbol passes through a fixed output pipeline, so the last data symbol leaves two symbol periods after input-empty rises. An interrupt flag drives an active-low interrupt line. Reading the status clears that flag.

The host must keep the mode inputs at interrupt-enable = 1, transmit = 1 and power-save = 0 for the block to run. The buffer depth parameter must be at least 12.

Top module: `modem_tx_top`

## Requirements
- R1: After reset, status reads 4'b0011: bit0 buffer-free = 1, bit1 input-empty = 1, bit2 interrupt = 0, bit3 symbol-ready = 0. irqN is high.
- R2: Task codes set the byte count: 1 = sync (6 bytes), 2 = station ID (3), 3 = header (10), 4 = intermediate (12), 5 = last block (8). Codes 0, 6 and 7 are ignored and send nothing.
- R3: Each byte goes out as four symbols, most significant dibit first, one symbol per strobe. The strobe period is clkDiv+1 clock cycles and symTick pulses once for each symbol. The bytes of a task go out back to back, in write order. Every command write resets the byte write address to 0.
- R4: When a queued task moves into the transmit stage, the block sets buffer-free to 1 and interrupt to 1, and clears input-empty to 0.
- R5: A task queued while another is being sent starts on the strobe right after the current task's last symbol, with no filler symbol between them.
- R6: When the stage runs out after a last-block task, the block sets input-empty and raises an interrupt again. The status then reads buffer-free = 1, input-empty = 1, interrupt = 1.
- R7: While buffer-free is 0, command writes and byte writes are ignored.
- R8: A status read (statusRdEn high for one cycle) clears the interrupt and symbol-ready flags. irqN equals NOT (interrupt AND modeIrqEn).
- R9: When no data is queued, each strobe sends modeFiller. This field can change at any time. With modeSymIrqEn = 1, each filler symbol sets symbol-ready and interrupt.
- R10: With modeInvert = 1, every output symbol is XORed with 2'b11.
- R11: A symbol chosen on a strobe appears on symOut two strobes later. The last data symbol of a task appears on the second symTick after the symTick on which input-empty rises.
- R12: Unless modeIrqEn = 1, modeTxMode = 1 and modePowerSave = 0, the strobe stops, so symTick stays low. Command writes are ignored in this case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byteWrEn | input | 1 | Write one byte into the data buffer |
| byteWrData | input | 8 | Byte to write |
| cmdWrEn | input | 1 | Write a task code |
| cmdCode | input | 3 | Task code |
| statusRdEn | input | 1 | Status read strobe; clears the interrupt and symbol-ready flags |
| status | output | 4 | {symbol-ready, interrupt, input-empty, buffer-free} |
| irqN | output | 1 | Active-low interrupt line |
| modeIrqEn | input | 1 | Interrupt enable |
| modeTxMode | input | 1 | Transmit mode select |
| modePowerSave | input | 1 | Power save; stops the block |
| modeSymIrqEn | input | 1 | Interrupt on each filler symbol |
| modeInvert | input | 1 | Invert the symbol mapping |
| modeFiller | input | 2 | Filler symbol |
| clkDiv | input | DIV_W | Strobe divider; period is clkDiv+1 cycles |
| symOut | output | 2 | Output symbol after the pipeline |
| symTick | output | 1 | Pulses when symOut advances |

## Verification
Each task code is applied once, with byte patterns made only of dibits 01 and 10, so data symbols can never be mistaken for filler 00 or its inverse 11. This separates a wrong byte count, a wrong dibit order and a gap in the stream. A back-to-back intermediate-then-last pair checks that the queued block follows without a filler gap. A third command and some stray byte writes are made while the buffer is held, and they must not change the stream. The inverted mapping, a changed filler and a stopped mode show whether the output mapping, the filler path and the enable gating act on their own.

// File: rtl/modem_tx_pkg.sv
package modem_tx_pkg;

  typedef enum logic [2:0] {
    TASK_NONE    = 3'd0,
    TASK_SYNC    = 3'd1,
    TASK_STATION = 3'd2,
    TASK_HEADER  = 3'd3,
    TASK_INTER   = 3'd4,
    TASK_LAST    = 3'd5
  } taskCode_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadStage;
    logic shiftData;
    logic shiftFiller;
  } dpCtrl_t;

  function automatic logic [4:0] taskBytes(input logic [2:0] code);
    case (code)
      TASK_SYNC:    taskBytes = 5'd6;
      TASK_STATION: taskBytes = 5'd3;
      TASK_HEADER:  taskBytes = 5'd10;
      TASK_INTER:   taskBytes = 5'd12;
      TASK_LAST:    taskBytes = 5'd8;
      default:      taskBytes = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/modem_tx_ctrl.sv
module modem_tx_ctrl
  import modem_tx_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int DIV_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdWrEn,
  input  logic [2:0]       cmdCode,
  input  logic             statusRdEn,
  input  logic             modeIrqEn,
  input  logic             modeTxMode,
  input  logic             modePowerSave,
  input  logic             modeSymIrqEn,
  input  logic [DIV_W-1:0] clkDiv,
  output dpCtrl_t          dpCtrl,
  output logic             bufFree,
  output logic             inEmpty,
  output logic             irqFlag,
  output logic             symRdy
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int DIB_W = CNT_W + 2;

  logic             enabled;
  logic [DIV_W-1:0] divCnt;
  logic             symStrobe;
  logic [CNT_W-1:0] codeBytes;
  logic             cmdAccept;
  logic [CNT_W-1:0] pendBytes;
  logic             pendLast;
  logic [DIB_W-1:0] dibitsLeft;
  logic             stageLast;
  logic             stageIdle;
  logic             stageDone;
  logic             fillerIrq;

  assign enabled   = modeIrqEn && modeTxMode && !modePowerSave;
  assign symStrobe = enabled && (divCnt >= clkDiv);
  assign codeBytes = CNT_W'(taskBytes(cmdCode));
  assign cmdAccept = cmdWrEn && enabled && bufFree && (codeBytes != '0);
  assign stageIdle = (dibitsLeft == '0);

  assign dpCtrl.loadStage   = !bufFree && stageIdle;
  assign dpCtrl.shiftData   = symStrobe && !stageIdle;
  assign dpCtrl.shiftFiller = symStrobe && stageIdle;

  assign stageDone = dpCtrl.shiftData && (dibitsLeft == DIB_W'(1));
  assign fillerIrq = dpCtrl.shiftFiller && modeSymIrqEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 divCnt <= '0;
    else if (!enabled)          divCnt <= '0;
    else if (divCnt >= clkDiv)  divCnt <= '0;
    else                        divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufFree   <= 1'b1;
      pendBytes <= '0;
      pendLast  <= 1'b0;
    end else if (cmdAccept) begin
      bufFree   <= 1'b0;
      pendBytes <= codeBytes;
      pendLast  <= (cmdCode == TASK_LAST);
    end else if (dpCtrl.loadStage) begin
      bufFree   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dibitsLeft <= '0;
      stageLast  <= 1'b0;
    end else if (dpCtrl.loadStage) begin
      dibitsLeft <= {pendBytes, 2'b00};
      stageLast  <= pendLast;
    end else if (dpCtrl.shiftData) begin
      dibitsLeft <= dibitsLeft - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inEmpty <= 1'b1;
      irqFlag <= 1'b0;
      symRdy  <= 1'b0;
    end else begin
      if (dpCtrl.loadStage)                        inEmpty <= 1'b0;
      else if (stageDone && (stageLast || bufFree)) inEmpty <= 1'b1;

      if (dpCtrl.loadStage || (stageDone && stageLast) || fillerIrq) irqFlag <= 1'b1;
      else if (statusRdEn)                                           irqFlag <= 1'b0;

      if (fillerIrq)       symRdy <= 1'b1;
      else if (statusRdEn) symRdy <= 1'b0;
    end
  end

  assert_one_symbol_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dpCtrl.shiftData, dpCtrl.shiftFiller}));

  assert_load_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dpCtrl.loadStage |=> (bufFree && irqFlag && !inEmpty));

  assert_queued_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stageDone && !bufFree) |=> dpCtrl.loadStage);

  assert_last_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stageDone && stageLast) |=> (inEmpty && irqFlag));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRdEn && !dpCtrl.loadStage && !dpCtrl.shiftData && !dpCtrl.shiftFiller)
      |=> !irqFlag);

  assert_filler_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fillerIrq |=> (symRdy && irqFlag));

  assert_cmd_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrEn && !enabled && bufFree) |=> bufFree);

endmodule

// File: rtl/modem_tx_dp.sv
module modem_tx_dp
  import modem_tx_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int LAT_SYM   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byteWrEn,
  input  logic [7:0] byteWrData,
  input  logic       cmdWrEn,
  input  logic       bufFree,
  input  logic [1:0] modeFiller,
  input  logic       modeInvert,
  input  dpCtrl_t    dpCtrl,
  output logic [1:0] symOut,
  output logic       symTick
);

  localparam int PTR_W = $clog2(BUF_DEPTH);

  logic [7:0]     bufMem [BUF_DEPTH];
  logic [7:0]     txMem  [BUF_DEPTH];
  logic [PTR_W:0] wrPtr;
  logic [PTR_W:0] rdIdx;
  logic [1:0]     dibIdx;
  logic           wrOk;
  logic [7:0]     curByte;
  logic [1:0]     dataSym;
  logic [1:0]     mappedSym;
  logic           strobe;
  logic [1:0]     pipe [LAT_SYM+1];

  assign wrOk    = byteWrEn && bufFree && (wrPtr < (PTR_W+1)'(BUF_DEPTH));
  assign curByte = txMem[rdIdx[PTR_W-1:0]];
  assign dataSym = 2'(curByte >> (3'd6 - {dibIdx, 1'b0}));
  assign mappedSym = (dpCtrl.shiftData ? dataSym : modeFiller) ^ {2{modeInvert}};
  assign strobe  = dpCtrl.shiftData || dpCtrl.shiftFiller;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wrPtr <= '0;
    else if (cmdWrEn) wrPtr <= '0;
    else if (wrOk)    wrPtr <= wrPtr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_DEPTH; i++) bufMem[i] <= '0;
    end else if (wrOk) begin
      bufMem[wrPtr[PTR_W-1:0]] <= byteWrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_DEPTH; i++) txMem[i] <= '0;
    end else if (dpCtrl.loadStage) begin
      for (int i = 0; i < BUF_DEPTH; i++) txMem[i] <= bufMem[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdIdx  <= '0;
      dibIdx <= '0;
    end else if (dpCtrl.loadStage) begin
      rdIdx  <= '0;
      dibIdx <= '0;
    end else if (dpCtrl.shiftData) begin
      dibIdx <= dibIdx + 1'b1;
      if (dibIdx == 2'd3) rdIdx <= rdIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= LAT_SYM; s++) pipe[s] <= '0;
      symTick <= 1'b0;
    end else begin
      symTick <= strobe;
      if (strobe) begin
        pipe[0] <= mappedSym;
        for (int s = 1; s <= LAT_SYM; s++) pipe[s] <= pipe[s-1];
      end
    end
  end

  assign symOut = pipe[LAT_SYM];

  assert_read_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dpCtrl.shiftData |-> (rdIdx < (PTR_W+1)'(BUF_DEPTH)));

endmodule

// File: rtl/modem_tx_top.sv
module modem_tx_top
  import modem_tx_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int DIV_W     = 8,
  parameter int LAT_SYM   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byteWrEn,
  input  logic [7:0]       byteWrData,
  input  logic             cmdWrEn,
  input  logic [2:0]       cmdCode,
  input  logic             statusRdEn,
  output logic [3:0]       status,
  output logic             irqN,
  input  logic             modeIrqEn,
  input  logic             modeTxMode,
  input  logic             modePowerSave,
  input  logic             modeSymIrqEn,
  input  logic             modeInvert,
  input  logic [1:0]       modeFiller,
  input  logic [DIV_W-1:0] clkDiv,
  output logic [1:0]       symOut,
  output logic             symTick
);

  dpCtrl_t dpCtrl;
  logic    bufFree;
  logic    inEmpty;
  logic    irqFlag;
  logic    symRdy;

  modem_tx_ctrl #(.BUF_DEPTH(BUF_DEPTH), .DIV_W(DIV_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmdWrEn       (cmdWrEn),
    .cmdCode       (cmdCode),
    .statusRdEn    (statusRdEn),
    .modeIrqEn     (modeIrqEn),
    .modeTxMode    (modeTxMode),
    .modePowerSave (modePowerSave),
    .modeSymIrqEn  (modeSymIrqEn),
    .clkDiv        (clkDiv),
    .dpCtrl        (dpCtrl),
    .bufFree       (bufFree),
    .inEmpty       (inEmpty),
    .irqFlag       (irqFlag),
    .symRdy        (symRdy)
  );

  modem_tx_dp #(.BUF_DEPTH(BUF_DEPTH), .LAT_SYM(LAT_SYM)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .byteWrEn   (byteWrEn),
    .byteWrData (byteWrData),
    .cmdWrEn    (cmdWrEn),
    .bufFree    (bufFree),
    .modeFiller (modeFiller),
    .modeInvert (modeInvert),
    .dpCtrl     (dpCtrl),
    .symOut     (symOut),
    .symTick    (symTick)
  );

  assign status = {symRdy, irqFlag, inEmpty, bufFree};
  assign irqN   = !(irqFlag && modeIrqEn);

endmodule

// File: tb/modem_tx_top_bench.sv
module modem_tx_top_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byteWrEn, cmdWrEn, statusRdEn;
  logic [7:0] byteWrData;
  logic [2:0] cmdCode;
  logic [3:0] status;
  logic       irqN;
  logic       modeIrqEn, modeTxMode, modePowerSave, modeSymIrqEn, modeInvert;
  logic [1:0] modeFiller;
  logic [7:0] clkDiv;
  logic [1:0] symOut;
  logic       symTick;

  always #5 clk = ~clk;

  modem_tx_top u_modem_tx_top (
    .clk(clk), .rst_n(rst_n), .byteWrEn(byteWrEn), .byteWrData(byteWrData),
    .cmdWrEn(cmdWrEn), .cmdCode(cmdCode), .statusRdEn(statusRdEn),
    .status(status), .irqN(irqN), .modeIrqEn(modeIrqEn), .modeTxMode(modeTxMode),
    .modePowerSave(modePowerSave), .modeSymIrqEn(modeSymIrqEn),
    .modeInvert(modeInvert), .modeFiller(modeFiller), .clkDiv(clkDiv),
    .symOut(symOut), .symTick(symTick)
  );

  // {code, byte count}
  localparam logic [7:0] VEC [8] = '{
    {3'd1, 5'd6}, {3'd2, 5'd3}, {3'd3, 5'd10}, {3'd4, 5'd12},
    {3'd5, 5'd8}, {3'd0, 5'd0}, {3'd6, 5'd0}, {3'd7, 5'd0}
  };

  logic [1:0] cap [0:4095];
  int         capN = 0;
  int         emptyIdx = -1;
  logic       prevEmpty = 1'b1;
  logic [1:0] expSeq [0:255];
  int         expN;
  int         nChecks = 0;
  int         nFail = 0;
  logic       timedOut = 1'b0;

  always @(negedge clk) begin
    if (symTick && capN < 4096) begin
      cap[capN] = symOut;
      if (status[1] && !prevEmpty) emptyIdx = capN;
      prevEmpty = status[1];
      capN = capN + 1;
    end
  end

  function automatic logic [1:0] dib(input logic x);
    return x ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [7:0] patRaw(input int seed, input int i);
    return 8'(seed * 37 + i * 11 + 5);
  endfunction

  function automatic logic [7:0] patByte(input int seed, input int i);
    logic [7:0] b;
    b = patRaw(seed, i);
    return {dib(b[3]), dib(b[2]), dib(b[1]), dib(b[0])};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeBytes(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      byteWrData = patByte(seed, i);
      byteWrEn = 1'b1;
      tick();
      byteWrEn = 1'b0;
    end
  endtask

  task automatic addExp(input int n, input int seed);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      b = patRaw(seed, i);
      for (int d = 0; d < 4; d++) begin
        expSeq[expN] = dib(b[3-d]);
        expN++;
      end
    end
  endtask

  task automatic sendCmd(input logic [2:0] code);
    cmdCode = code;
    cmdWrEn = 1'b1;
    tick();
    cmdWrEn = 1'b0;
  endtask

  task automatic readStatus(output logic [3:0] st);
    st = status;
    statusRdEn = 1'b1;
    tick();
    statusRdEn = 1'b0;
  endtask

  task automatic waitIrq(input string tag);
    int n;
    n = 0;
    while (irqN && n < 2000) begin tick(); n++; end
    check(!irqN, tag, irqN, 0);
  endtask

  task automatic waitTicks(input int n);
    int target;
    target = capN + n;
    while (capN < target) tick();
  endtask

  task automatic checkStream(input int base, input logic inv, input string tag, output int f);
    logic [1:0] fm;
    int bad;
    fm = modeFiller ^ {2{inv}};
    f = base;
    while (f < capN && cap[f] == fm) f++;
    if (expN == 0) begin
      check(f == capN, {tag, " no data expected"}, f, capN);
    end else begin
      bad = 0;
      for (int k = 0; k < expN; k++)
        if (f + k >= capN || cap[f+k] != (expSeq[k] ^ {2{inv}})) bad++;
      check(bad == 0, {tag, " data symbols"}, bad, 0);
      check(f + expN < capN && cap[f+expN] == fm, {tag, " filler after data"},
            cap[f+expN], fm);
    end
  endtask

  task automatic runAll();
    logic [3:0] st;
    int base, f, n;
    logic [2:0] code;

    // R1: reset state
    check(status == 4'b0011, "R1 status after reset", status, 4'b0011);
    check(irqN == 1'b1, "R1 irqN after reset", irqN, 1);

    // table walk: R2, R3, R4, R6, R11
    for (int v = 0; v < 8; v++) begin
      code = VEC[v][7:5];
      n = int'(VEC[v][4:0]);
      base = capN;
      expN = 0;
      writeBytes((n == 0) ? 4 : n, v + 1);
      addExp(n, v + 1);
      sendCmd(code);
      if (n > 0) begin
        waitIrq("R4 irq on load");
        readStatus(st);
        check(st[2:0] == 3'b101, "R4 status after load", st, 3'b101);
        if (code == 3'd5) begin
          waitIrq("R6 irq on empty");
          readStatus(st);
          check(st[2:0] == 3'b111, "R6 status at end", st, 3'b111);
        end
        waitTicks(4 * n + 8);
        checkStream(base, 1'b0, "R2 R3 task", f);
        check(f + expN - 1 == emptyIdx + 2, "R11 last symbol latency",
              f + expN - 1 - emptyIdx, 2);
      end else begin
        waitTicks(16);
        check(irqN && status[0], "R2 invalid code ignored", {irqN, status[0]}, 2'b11);
        checkStream(base, 1'b0, "R2 invalid code", f);
      end
    end

    // R5 and R7: back-to-back tasks, third command and byte writes ignored
    base = capN;
    expN = 0;
    writeBytes(12, 20); addExp(12, 20);
    sendCmd(3'd4);
    waitIrq("R4 first load");
    readStatus(st);
    writeBytes(8, 21); addExp(8, 21);
    sendCmd(3'd5);
    tick();
    check(status[0] == 1'b0, "R7 buffer held", status[0], 0);
    writeBytes(3, 99);
    sendCmd(3'd2);
    waitIrq("R5 queued load irq");
    readStatus(st);
    check(st[2:0] == 3'b101, "R5 status after queued load", st, 3'b101);
    waitIrq("R6 end irq");
    readStatus(st);
    check(st[2:0] == 3'b111, "R6 status after pair", st, 3'b111);
    waitTicks(20);
    checkStream(base, 1'b0, "R5 R7 pair", f);

    // R9 and R8: filler interrupt and read clearing
    modeSymIrqEn = 1'b1;
    waitIrq("R9 filler irq");
    modeSymIrqEn = 1'b0;
    tick();
    readStatus(st);
    check(st[3:2] == 2'b11, "R9 symbol-ready set", st, 4'b1100);
    check(status == 4'b0011, "R8 read clears flags", status, 4'b0011);
    check(irqN == 1'b1, "R8 irqN released", irqN, 1);

    // R9: filler selection
    modeFiller = 2'b10;
    waitTicks(6);
    check(cap[capN-1] == 2'b10 && cap[capN-2] == 2'b10, "R9 filler changed",
          cap[capN-1], 2'b10);
    modeFiller = 2'b00;
    waitTicks(4);

    // R10: inverted mapping
    modeInvert = 1'b1;
    waitTicks(4);
    base = capN;
    expN = 0;
    writeBytes(10, 30); addExp(10, 30);
    sendCmd(3'd3);
    waitIrq("R10 load irq");
    readStatus(st);
    waitTicks(50);
    checkStream(base, 1'b1, "R10 inverted", f);
    modeInvert = 1'b0;
    waitTicks(4);

    // R12: stopped mode
    modeTxMode = 1'b0;
    tick();
    base = capN;
    writeBytes(6, 40);
    sendCmd(3'd1);
    repeat (40) tick();
    check(capN == base, "R12 no symbol ticks", capN - base, 0);
    check(status[0] == 1'b1 && irqN, "R12 command ignored", status, 4'b0011);
    modeTxMode = 1'b1;
    base = capN;
    expN = 0;
    waitTicks(20);
    checkStream(base, 1'b0, "R12 nothing sent", f);
  endtask

  initial begin
    rst_n = 1'b0; byteWrEn = 1'b0; cmdWrEn = 1'b0; statusRdEn = 1'b0;
    byteWrData = '0; cmdCode = '0;
    modeIrqEn = 1'b1; modeTxMode = 1'b1; modePowerSave = 1'b0;
    modeSymIrqEn = 1'b0; modeInvert = 1'b0; modeFiller = 2'b00; clkDiv = 8'd3;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    fork
      runAll();
      begin
        repeat (200000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    if (timedOut) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule